// File: doc/BRIEF.md
# IF Control Register Bank on a Multiplexed Bus

This block is a write-only peripheral that sits on an 8-bit shared address/data bus and holds the control words for a receiver's IF section. A bus master first places a register address on the bus and pulses the address strobe `ale`, which captures the low address bits. It then places the data word on the same bus and pulses the active-low write strobe `wr_n`. While `wr_n` is low, a 3-to-8 decoder pulls the selected line low. When `wr_n` returns high, that line rises, and the rising edge commits the data into the addressed register.

Both strobes and the bus are brought into the system clock domain through synchronizer chains of equal length. This keeps the data aligned with the strobes, and all edge detection happens on `clk`. Only four of the eight decode codes are mapped: 0, 1, 2 and 7. The other four codes accept a write cycle and store nothing.

The bandwidth register drives the one-hot bandwidth selection, the AGC dump line and the BFO inhibit line. Register B drives the stereo headphone routing select and the manual-gain select.

Top module: `ifctl_regbank`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, all four register words and every derived control output are zero after that edge.
- R2: A write to address 1 loads the bandwidth word `bw_q`. `bw_sel` equals bits 4..0 of that word (bit 0 = 16 kHz, bit 1 = 6 kHz, bit 2 = 3.2 kHz, bit 3 = 1 kHz, bit 4 = 0.3 kHz). `agc_dump` equals bit 5 and `bfo_inhibit` equals bit 7.
- R3: A write to address 0 loads `ctl_lo_q`, a write to address 2 loads `regb_q` and a write to address 7 loads `ctl_hi_q`. No other register changes.
- R4: A write cycle to address 3, 4, 5 or 6 leaves all four register words unchanged.
- R5: While `wr_n` stays low, no register word changes. The commit happens only after `wr_n` returns high.
- R6: A write cycle issued before any `ale` pulse since reset changes no register.
- R7: `isb_route` equals bit 0 of `regb_q`, and `man_gain_sel` equals bit 1 of `regb_q`.
- R8: A latched address stays in force until the next `ale` pulse, so several write cycles after one `ale` all land in the same register.
- R9: With `SYNC_STAGES` = 2, suppose `wr_n` is first sampled high at rising edge k after being low at edge k-1. The new register value then appears after edge k+2, and the old value is still present after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ad | input | 8 | Shared address/data bus |
| ale | input | 1 | Address strobe, active high |
| wr_n | input | 1 | Write strobe, active low, commit on its return high |
| ctl_lo_q | output | 8 | Register at address 0 |
| bw_q | output | 8 | Bandwidth register (address 1) |
| regb_q | output | 8 | Register B (address 2) |
| ctl_hi_q | output | 8 | Register at address 7 |
| bw_sel | output | 5 | One-hot bandwidth selection |
| agc_dump | output | 1 | AGC dump, holds off signal-strength energy |
| bfo_inhibit | output | 1 | BFO inhibit outside CW |
| isb_route | output | 1 | Headphone routing: upper sideband on tip, lower on ring |
| man_gain_sel | output | 1 | Manual RF gain path select |

## Verification
The bench builds the block with its defaults: an 8-bit bus, 3 address bits and 2-stage synchronizers. With this configuration the whole decode space and every data value fit in one exhaustive sweep, 8 addresses by 256 words. Each write in the sweep also checks exact commit latency and that nothing moves while the strobe is held low. The two-stage setting is what makes the cycle-exact latency property possible.

// File: rtl/ifctl_pkg.sv
package ifctl_pkg;

   localparam int NUM_SLOTS      = 4;
   localparam int BW_SEL_W       = 5;
   localparam int BW_DUMP_BIT    = 5;
   localparam int BW_BFO_BIT     = 7;
   localparam int REGB_ISB_BIT   = 0;
   localparam int REGB_MGAIN_BIT = 1;

   typedef enum logic [1:0] {
      SLOT_CLO = 2'd0,
      SLOT_BW  = 2'd1,
      SLOT_B   = 2'd2,
      SLOT_CHI = 2'd3
   } slot_e;

   // Decode code that feeds each storage slot (sparse map)
   function automatic int slot_code(input int slot);
      case (slot)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/ifctl_sync.sv
module ifctl_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ifctl_addr_dec.sv
module ifctl_addr_dec #(
   parameter int ADDR_BITS = 3,
   parameter int DATA_W    = 8,
   localparam int NCODES   = 1 << ADDR_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale_s,
   input  logic              wr_s,
   input  logic [DATA_W-1:0] bus_s,
   output logic [NCODES-1:0] load
);

   logic [ADDR_BITS-1:0] addr_q;
   logic                 addr_valid;
   logic [NCODES-1:0]    sel_n;
   logic [NCODES-1:0]    sel_n_prev;
   logic                 dec_en;
   logic                 unused_hi_bits;

   // Address capture: follows the bus while the strobe is high, holds after
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q     <= '0;
         addr_valid <= 1'b0;
      end else if (ale_s) begin
         addr_q     <= bus_s[ADDR_BITS-1:0];
         addr_valid <= 1'b1;
      end
   end

   generate
      if (DATA_W > ADDR_BITS) begin : g_hi
         assign unused_hi_bits = ^bus_s[DATA_W-1:ADDR_BITS];
      end else begin : g_nohi
         assign unused_hi_bits = 1'b0;
      end
   endgenerate

   // Decoder enabled only while the write strobe is low
   assign dec_en = ~wr_s & addr_valid;

   generate
      for (genvar c = 0; c < NCODES; c++) begin : g_dec
         assign sel_n[c] = ~(dec_en && (addr_q == c[ADDR_BITS-1:0]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) sel_n_prev <= '1;
      else     sel_n_prev <= sel_n;
   end

   // Trailing (rising) edge of a select line commits the write
   assign load = sel_n & ~sel_n_prev;

endmodule

// File: rtl/ifctl_reg.sv
module ifctl_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/ifctl_regbank.sv
module ifctl_regbank
   import ifctl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_BITS   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] bus_ad,
   input  logic              ale,
   input  logic              wr_n,
   output logic [DATA_W-1:0] ctl_lo_q,
   output logic [DATA_W-1:0] bw_q,
   output logic [DATA_W-1:0] regb_q,
   output logic [DATA_W-1:0] ctl_hi_q,
   output logic [4:0]        bw_sel,
   output logic              agc_dump,
   output logic              bfo_inhibit,
   output logic              isb_route,
   output logic              man_gain_sel
);

   localparam int NCODES = 1 << ADDR_BITS;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("ifctl_regbank: DATA_W must be at least 8");
      end
      if (ADDR_BITS < 3) begin : g_bad_addr
         $error("ifctl_regbank: ADDR_BITS must reach decode code 7");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ifctl_regbank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              ale_s;
   logic              wr_s;
   logic [DATA_W-1:0] bus_s;
   logic [NCODES-1:0] load;
   logic [NCODES-1:0] mapped;
   logic [DATA_W-1:0] word_q [NUM_SLOTS];
   logic              unused_loads;
   logic [DATA_W-1:0] unused_word_bits;

   ifctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ale (
      .clk(clk), .rst(rst), .d(ale), .q(ale_s));

   ifctl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wr (
      .clk(clk), .rst(rst), .d(wr_n), .q(wr_s));

   // Bus delayed by the same depth so it lines up with the strobes
   ifctl_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst(rst), .d(bus_ad), .q(bus_s));

   ifctl_addr_dec #(.ADDR_BITS(ADDR_BITS), .DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst(rst), .ale_s(ale_s), .wr_s(wr_s), .bus_s(bus_s),
      .load(load));

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         localparam int CODE = slot_code(s);
         assign mapped[CODE] = 1'b1;
         ifctl_reg #(.DATA_W(DATA_W)) u_reg (
            .clk(clk), .rst(rst), .load(load[CODE]), .d(bus_s),
            .q(word_q[s]));
      end
      for (genvar c = 0; c < NCODES; c++) begin : g_map
         if (c != 0 && c != 1 && c != 2 && c != 7) begin : g_un
            assign mapped[c] = 1'b0;
         end
      end
   endgenerate

   // Codes outside the map decode but store nothing
   assign unused_loads = |(load & ~mapped);

   assign ctl_lo_q = word_q[SLOT_CLO];
   assign bw_q     = word_q[SLOT_BW];
   assign regb_q   = word_q[SLOT_B];
   assign ctl_hi_q = word_q[SLOT_CHI];

   assign bw_sel       = bw_q[BW_SEL_W-1:0];
   assign agc_dump     = bw_q[BW_DUMP_BIT];
   assign bfo_inhibit  = bw_q[BW_BFO_BIT];
   assign isb_route    = regb_q[REGB_ISB_BIT];
   assign man_gain_sel = regb_q[REGB_MGAIN_BIT];

   assign unused_word_bits = bw_q & regb_q;

endmodule

// File: rtl/ifctl_regbank_chk.sv
module ifctl_regbank_chk #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              ale,
   input logic              wr_n,
   input logic [DATA_W-1:0] ctl_lo_q,
   input logic [DATA_W-1:0] bw_q,
   input logic [DATA_W-1:0] regb_q,
   input logic [DATA_W-1:0] ctl_hi_q,
   input logic              agc_dump,
   input logic              isb_route
);

   logic [4*DATA_W-1:0] words;
   logic                ale_seen;

   assign words = {ctl_lo_q, bw_q, regb_q, ctl_hi_q};

   always_ff @(posedge clk) begin
      if (rst)      ale_seen <= 1'b0;
      else if (ale) ale_seen <= 1'b1;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (words == '0 && !agc_dump && !isb_route));

   // R5
   hold_while_low_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_n, 2) |=> $stable(words));

   // R6
   no_ale_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      !ale_seen |-> (words == '0));

   generate
      if (SYNC_STAGES == 2) begin : g_lat
         // R9
         commit_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$stable(words)) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));
      end
   endgenerate

endmodule

bind ifctl_regbank ifctl_regbank_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst(rst), .ale(ale), .wr_n(wr_n),
   .ctl_lo_q(ctl_lo_q), .bw_q(bw_q), .regb_q(regb_q), .ctl_hi_q(ctl_hi_q),
   .agc_dump(agc_dump), .isb_route(isb_route));

// File: tb/ifctl_regbank_tb.sv
module ifctl_regbank_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] bus_ad = 8'h00;
   logic       ale = 1'b0;
   logic       wr_n = 1'b1;
   logic [7:0] ctl_lo_q, bw_q, regb_q, ctl_hi_q;
   logic [4:0] bw_sel;
   logic       agc_dump, bfo_inhibit, isb_route, man_gain_sel;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [7:0] m [8];

   always #2 clk = ~clk;

   ifctl_regbank u_dut (
      .clk(clk), .rst(rst), .bus_ad(bus_ad), .ale(ale), .wr_n(wr_n),
      .ctl_lo_q(ctl_lo_q), .bw_q(bw_q), .regb_q(regb_q), .ctl_hi_q(ctl_hi_q),
      .bw_sel(bw_sel), .agc_dump(agc_dump), .bfo_inhibit(bfo_inhibit),
      .isb_route(isb_route), .man_gain_sel(man_gain_sel));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_words(input string req);
      chk(req, ctl_lo_q, m[0]);
      chk(req, bw_q,     m[1]);
      chk(req, regb_q,   m[2]);
      chk(req, ctl_hi_q, m[7]);
   endtask

   task automatic check_all(input string req);
      check_words(req);
      chk("R2", {3'b0, bw_sel}, {3'b0, m[1][4:0]});
      chk("R2", {7'b0, agc_dump}, {7'b0, m[1][5]});
      chk("R2", {7'b0, bfo_inhibit}, {7'b0, m[1][7]});
      chk("R7", {7'b0, isb_route}, {7'b0, m[2][0]});
      chk("R7", {7'b0, man_gain_sel}, {7'b0, m[2][1]});
   endtask

   task automatic do_ale(input logic [7:0] a);
      @(negedge clk);
      bus_ad = a; ale = 1'b1;
      repeat (3) @(negedge clk);
      ale = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // Write cycle; 'commits' tells whether the model gets updated at addr a
   task automatic do_wr(input logic [7:0] d, input int hold, input logic [2:0] a,
                        input bit commits, input string req);
      @(negedge clk);
      bus_ad = d; wr_n = 1'b0;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check_words("R5");
      end
      wr_n = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      check_words("R9");
      if (commits && (a == 3'd0 || a == 3'd1 || a == 3'd2 || a == 3'd7)) m[a] = d;
      @(posedge clk); #1;
      check_all(req);
      repeat (2) @(negedge clk);
   endtask

   function automatic string req_for(input int a);
      if (a == 1) return "R2";
      if (a == 0 || a == 2 || a == 7) return "R3";
      return "R4";
   endfunction

   initial begin
      for (int i = 0; i < 8; i++) m[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_all("R1");

      // R6: write with no address strobe since reset
      do_wr(8'hFF, 2, 3'd1, 1'b0, "R6");
      do_wr(8'hA5, 2, 3'd0, 1'b0, "R6");

      // R8: one address strobe, two writes land in the same register
      do_ale(8'h02);
      do_wr(8'h01, 2, 3'd2, 1'b1, "R8");
      do_wr(8'h03, 2, 3'd2, 1'b1, "R8");
      chk("R8", regb_q, 8'h03);

      // R5: long strobe hold
      do_ale(8'h07);
      do_wr(8'h5A, 8, 3'd7, 1'b1, "R5");

      // Exhaustive sweep: every address, every data word
      for (int a = 0; a < 8; a++) begin
         for (int d = 0; d < 256; d++) begin
            do_ale(8'(a) | 8'hF8 & 8'(d));
            do_wr(8'(d), 1 + (d % 3), 3'(a), 1'b1, req_for(a));
         end
      end

      // Upper bus bits during address phase are ignored (R3)
      do_ale(8'hF9);
      do_wr(8'h3C, 2, 3'd1, 1'b1, "R2");

      // R1: reset in the middle of operation
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 8; i++) m[i] = 8'h00;
      check_all("R1");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule